// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an external asynchronous 16-bit static RAM with two chip selects (one active-low, one active-high), an output enable, a write enable and one active-low enable per byte lane. The host issues single-word read or write requests through a valid/ready handshake. The controller turns each request into a strobe sequence whose phase lengths are counted in clock cycles. These counts are derived from nanosecond timing minimums by rounding up against a clock-period parameter.

The data bus toward the memory is split into an outbound word, an inbound word and an output-drive enable that a pad ring or tristate buffer uses. A read keeps the memory selected with its outputs enabled for the access-time count, then captures the word on the closing clock edge and returns it with a one-cycle response pulse. A write first waits out the float time of the memory's outputs with output enable high. It then pulses write enable low with data driven and holds the data one more cycle after write enable rises.

States: `ST_IDLE` (deselected, ready high), `ST_READ` (access window), `ST_TURN` (bus turnaround before a write), `ST_WPULSE` (write enable low), `ST_WHOLD` (data hold). Transitions: IDLE→READ on an accepted read, IDLE→TURN on an accepted write, READ→IDLE when the access count expires (the response is captured on this edge), TURN→WPULSE when the float count expires, WPULSE→WHOLD when the pulse count expires, WHOLD→IDLE after one cycle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever the controller is idle, `req_ready` is 1, the memory is deselected (`mem_sel_n`=1, `mem_sel`=0), `mem_rd_en_n`=1, `mem_wr_en_n`=1, every bit of `mem_lane_n` is 1, `mem_dq_oe`=0 and `rsp_valid`=0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the whole cycle has elapsed: RD_CYC cycles for a read, TURN_CYC+PULSE_CYC+1 cycles for a write. Each count is ceil(ns/CLK_NS), which gives RD_CYC=4, TURN_CYC=2 and PULSE_CYC=3 at defaults.
- R3: During a read, `mem_sel_n`=0, `mem_sel`=1, `mem_rd_en_n`=0 and `mem_wr_en_n`=1, and `mem_addr` carries the request address. Lane k is enabled (`mem_lane_n[k]`=0) exactly when `req_mask[k]`=1; bit 1 is the upper lane (data bits 15:8) and bit 0 the lower lane (bits 7:0). Read enable and write enable are never low together.
- R4: RD_CYC is the largest of the rounded-up address, output-enable, lane-enable access times and the read cycle time. `mem_dq_in` is sampled on the edge that ends the access window, so the response appears after RD_CYC cycles. `rsp_valid` is a one-cycle pulse, and lanes not enabled by the mask read as zero in `rsp_rdata`.
- R5: A write starts with TURN_CYC cycles in which the memory is selected with the address and lanes applied, `mem_rd_en_n`=1, `mem_wr_en_n`=1 and `mem_dq_oe`=0. TURN_CYC is the rounded-up output float time.
- R6: `mem_wr_en_n` is then low for exactly PULSE_CYC cycles with data driven throughout. PULSE_CYC is the largest of the rounded-up pulse width and data setup, the select/address setup less TURN_CYC, and the write cycle count less TURN_CYC+1.
- R7: After `mem_wr_en_n` rises, data stays driven and the memory stays selected for one cycle. The controller then deselects and releases the bus.
- R8: `mem_dq_oe` is 1 only during the write pulse and the hold cycle, never while `mem_rd_en_n` is 0 and never while deselected.
- R9: A write changes only the lanes whose mask bit is 1; a mask of 0 leaves the addressed word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (18) | Word address |
| req_wdata | input | DATA_W (16) | Write data |
| req_mask | input | LANES (2) | Per-lane enable, bit 1 upper byte |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | DATA_W (16) | Read data, disabled lanes zero |
| mem_addr | output | ADDR_W (18) | Memory address bus |
| mem_dq_out | output | DATA_W (16) | Data toward memory |
| mem_dq_in | input | DATA_W (16) | Data from memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_rd_en_n | output | 1 | Active-low output enable |
| mem_wr_en_n | output | 1 | Active-low write enable |
| mem_lane_n | output | LANES (2) | Active-low lane enables, bit 1 upper byte |

## Verification
The bench attaches a behavioural memory that measures, in real time, the access time before each capture, write pulse width, select and data setup before the write edge, and the gap between the memory releasing the bus and the controller driving it. A controller that sampled one cycle early or shortened the pulse would raise a violation. The bench sweeps every lane mask over both writes and reads, including mask 0, where a design that ignored the mask would corrupt the word or return stale bytes. It also runs a write immediately after a read, where a missing turnaround state would show as bus contention. Strobe values are checked cycle by cycle so a hold cycle dropped or a cycle count off by one shows up in the ready latency.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WPULSE,
        ST_WHOLD
    } ctrl_state_t;

    // Round a nanosecond minimum up to whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/sram_lane_mask.sv
module sram_lane_mask #(
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              active,
    input  logic [LANES-1:0]  lane_req,
    input  logic [DATA_W-1:0] raw_in,
    output logic [LANES-1:0]  lane_n,
    output logic [DATA_W-1:0] masked_out
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_n[g]             = !(active && lane_req[g]);
        assign masked_out[g*8 +: 8]  = lane_req[g] ? raw_in[g*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC    = 4,
    parameter int TURN_CYC  = 2,
    parameter int PULSE_CYC = 3,
    parameter int CNT_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_done,
    output logic             req_ready,
    output logic             accept,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             sel_act,
    output logic             rd_act,
    output logic             wr_act,
    output logic             drive,
    output logic             sample
);

    localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LD  = CNT_W'(TURN_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);

    ctrl_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx  = state;
        req_ready = 1'b0;
        accept    = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        sel_act   = 1'b1;
        rd_act    = 1'b0;
        wr_act    = 1'b0;
        drive     = 1'b0;
        sample    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                sel_act   = 1'b0;
                if (req_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_nx = ST_TURN;
                        tmr_val  = TURN_LD;
                    end else begin
                        state_nx = ST_READ;
                        tmr_val  = RD_LD;
                    end
                end
            end
            ST_READ: begin
                rd_act = 1'b1;
                if (tmr_done) begin
                    sample   = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            ST_TURN: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = PULSE_LD;
                    state_nx = ST_WPULSE;
                end
            end
            ST_WPULSE: begin
                wr_act = 1'b1;
                drive  = 1'b1;
                if (tmr_done) begin
                    state_nx = ST_WHOLD;
                end
            end
            ST_WHOLD: begin
                drive    = 1'b1;
                state_nx = ST_IDLE;
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 16,
    parameter int CLK_NS   = 20,
    parameter int T_RC_NS  = 70,
    parameter int T_AA_NS  = 70,
    parameter int T_OE_NS  = 35,
    parameter int T_BA_NS  = 70,
    parameter int T_WC_NS  = 70,
    parameter int T_WP_NS  = 55,
    parameter int T_CW_NS  = 60,
    parameter int T_DW_NS  = 30,
    parameter int T_FLT_NS = 25,
    localparam int LANES   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_rd_en_n,
    output logic              mem_wr_en_n,
    output logic [LANES-1:0]  mem_lane_n
);

    localparam int RD_CYC    = max2(max2(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)),
                                    max2(ns_to_cyc(T_BA_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS)));
    localparam int TURN_CYC  = ns_to_cyc(T_FLT_NS, CLK_NS);
    localparam int PULSE_CYC = max2(max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)),
                                    max2(ns_to_cyc(T_CW_NS, CLK_NS) - TURN_CYC,
                                         ns_to_cyc(T_WC_NS, CLK_NS) - TURN_CYC - 1));
    localparam int CNT_MAX   = max2(RD_CYC, max2(TURN_CYC, PULSE_CYC));
    localparam int CNT_W     = $clog2(CNT_MAX + 1);

    logic              accept, tmr_load, tmr_done;
    logic [CNT_W-1:0]  tmr_val;
    logic              sel_act, rd_act, wr_act, drive, sample;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;
    logic [DATA_W-1:0] rd_masked;

    sram_ctrl_fsm #(
        .RD_CYC    (RD_CYC),
        .TURN_CYC  (TURN_CYC),
        .PULSE_CYC (PULSE_CYC),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .tmr_done  (tmr_done),
        .req_ready (req_ready),
        .accept    (accept),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .sel_act   (sel_act),
        .rd_act    (rd_act),
        .wr_act    (wr_act),
        .drive     (drive),
        .sample    (sample)
    );

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_lane_mask #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_lanes (
        .active     (sel_act),
        .lane_req   (mask_q),
        .raw_in     (mem_dq_in),
        .lane_n     (mem_lane_n),
        .masked_out (rd_masked)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= sample;
            if (sample) begin
                rsp_rdata <= rd_masked;
            end
        end
    end

    assign mem_addr    = addr_q;
    assign mem_dq_out  = wdata_q;
    assign mem_dq_oe   = drive;
    assign mem_sel_n   = !sel_act;
    assign mem_sel     = sel_act;
    assign mem_rd_en_n = !rd_act;
    assign mem_wr_en_n = !wr_act;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS   = 20,
    parameter int T_WC_NS  = 70,
    parameter int T_WP_NS  = 55,
    parameter int T_CW_NS  = 60,
    parameter int T_DW_NS  = 30,
    parameter int T_FLT_NS = 25
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic rsp_valid,
    input logic mem_dq_oe,
    input logic mem_sel_n,
    input logic mem_sel,
    input logic mem_rd_en_n,
    input logic mem_wr_en_n
);

    localparam int TURN_CYC  = ns_to_cyc(T_FLT_NS, CLK_NS);
    localparam int PULSE_CYC = max2(max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)),
                                    max2(ns_to_cyc(T_CW_NS, CLK_NS) - TURN_CYC,
                                         ns_to_cyc(T_WC_NS, CLK_NS) - TURN_CYC - 1));

    logic [7:0] rdoff_cnt;
    logic [7:0] welo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdoff_cnt <= '0;
            welo_cnt  <= '0;
        end else begin
            rdoff_cnt <= !mem_rd_en_n ? 8'd0 : ((rdoff_cnt == 8'hFF) ? rdoff_cnt : rdoff_cnt + 8'd1);
            welo_cnt  <= mem_wr_en_n ? 8'd0 : ((welo_cnt == 8'hFF) ? welo_cnt : welo_cnt + 8'd1);
        end
    end

    a_r1_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_sel_n && !mem_sel && !mem_dq_oe && mem_rd_en_n && mem_wr_en_n));

    a_r3_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_en_n && !mem_wr_en_n));

    a_r4_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r5_turn_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (int'(rdoff_cnt) >= TURN_CYC));

    a_r6_pulse_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_en_n |-> mem_dq_oe);

    a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_en_n) |-> (int'(welo_cnt) == PULSE_CYC));

    a_r7_hold_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_en_n) |-> (mem_dq_oe && !mem_sel_n && mem_sel));

    a_r8_drive_rd_off: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_rd_en_n);

    a_r8_drive_selected: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_sel_n && mem_sel));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .CLK_NS   (CLK_NS),
    .T_WC_NS  (T_WC_NS),
    .T_WP_NS  (T_WP_NS),
    .T_CW_NS  (T_CW_NS),
    .T_DW_NS  (T_DW_NS),
    .T_FLT_NS (T_FLT_NS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .mem_dq_oe   (mem_dq_oe),
    .mem_sel_n   (mem_sel_n),
    .mem_sel     (mem_sel),
    .mem_rd_en_n (mem_rd_en_n),
    .mem_wr_en_n (mem_wr_en_n)
);

// File: tb/sram_lane_ctrl_bench.sv
`timescale 1ns/1ps
module sram_lane_ctrl_bench;

    localparam int AW = 18;
    localparam int DW = 16;
    localparam int LN = 2;
    localparam int CP = 20;
    // Expected cycle counts, rounded up from the ns minimums.
    localparam int B_RD    = (70 + CP - 1) / CP;
    localparam int B_TURN  = (25 + CP - 1) / CP;
    localparam int B_P1    = ((55 + CP - 1) / CP > (30 + CP - 1) / CP) ? (55 + CP - 1) / CP : (30 + CP - 1) / CP;
    localparam int B_P2    = ((60 + CP - 1) / CP - B_TURN > (70 + CP - 1) / CP - B_TURN - 1)
                             ? (60 + CP - 1) / CP - B_TURN : (70 + CP - 1) / CP - B_TURN - 1;
    localparam int B_PULSE = (B_P1 > B_P2) ? B_P1 : B_P2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [LN-1:0] req_mask = '0;
    logic          req_ready, rsp_valid, mem_dq_oe;
    logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [AW-1:0] mem_addr;
    logic          mem_sel_n, mem_sel, mem_rd_en_n, mem_wr_en_n;
    logic [LN-1:0] mem_lane_n;

    int n_chk = 0;
    int n_fail = 0;
    int viol = 0;

    always #(CP/2) clk = ~clk;

    sram_lane_ctrl u_sram_lane_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe),
        .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_rd_en_n(mem_rd_en_n),
        .mem_wr_en_n(mem_wr_en_n), .mem_lane_n(mem_lane_n)
    );

    // ---------------- behavioural memory with timing monitor ----------------
    logic [DW-1:0] model_mem [64];
    logic [DW-1:0] shadow    [64];
    logic          sel_on, mem_drives;
    realtime t_we_fall = 0.0, t_sel = 0.0, t_data = 0.0, t_rd_chg = 0.0, t_hist = 0.0;
    realtime t_mem_off = -1000.0;

    assign sel_on     = !mem_sel_n && mem_sel;
    assign mem_drives = sel_on && !mem_rd_en_n && mem_wr_en_n && (mem_lane_n != 2'b11);

    always_comb begin
        for (int k = 0; k < LN; k++) begin
            if (sel_on && !mem_rd_en_n && mem_wr_en_n && !mem_lane_n[k])
                mem_dq_in[k*8 +: 8] = model_mem[mem_addr[5:0]][k*8 +: 8];
            else
                mem_dq_in[k*8 +: 8] = 8'hC3;
        end
    end

    always @(negedge mem_wr_en_n) t_we_fall = $realtime;
    always @(posedge sel_on) t_sel = $realtime;
    always @(mem_dq_out or posedge mem_dq_oe) t_data = $realtime;
    always @(mem_addr or mem_sel_n or mem_sel or mem_rd_en_n or mem_lane_n) t_rd_chg = $realtime;
    always @(negedge mem_drives) t_mem_off = $realtime;

    always @(posedge mem_wr_en_n) begin
        if (rst_n && sel_on) begin
            if ($realtime - t_we_fall < 55.0) viol++;
            if ($realtime - t_sel < 60.0) viol++;
            if (!mem_dq_oe || ($realtime - t_data < 30.0)) viol++;
            for (int k = 0; k < LN; k++)
                if (!mem_lane_n[k]) model_mem[mem_addr[5:0]][k*8 +: 8] = mem_dq_out[k*8 +: 8];
        end
    end

    always @(posedge mem_dq_oe) begin
        if (rst_n && (($realtime - t_mem_off < 25.0) || mem_drives)) viol++;
    end

    always @(negedge clk) begin
        if (rst_n && rsp_valid && (($realtime - CP/2) - t_hist < 70.0)) viol++;
        t_hist = t_rd_chg;
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] lane_bits(input logic [LN-1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    task automatic issue(input bit wr, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic [LN-1:0] m);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LN-1:0] m);
        int n, we_lo, drv;
        bit prev_lo;
        issue(1'b1, a, d, m);
        n = 1; we_lo = 0; drv = 0; prev_lo = 1'b0;
        // R5: turnaround phase right after acceptance
        chk(sel_on && mem_rd_en_n && mem_wr_en_n && !mem_dq_oe, "R5", "turn strobes",
            {mem_sel_n, mem_sel, mem_rd_en_n, mem_wr_en_n, mem_dq_oe}, 5'b01110);
        chk(mem_lane_n == ~m && mem_addr == a, "R5", "turn lanes/addr", {14'd0, mem_lane_n, mem_addr}, {14'd0, ~m, a});
        while (!req_ready) begin
            if (!mem_wr_en_n) we_lo++;
            if (mem_dq_oe) drv++;
            if (prev_lo && mem_wr_en_n)
                chk(mem_dq_oe && sel_on, "R7", "hold after pulse", {mem_dq_oe, sel_on}, 2'b11);
            prev_lo = !mem_wr_en_n;
            @(negedge clk);
            n++;
        end
        chk(n == B_TURN + B_PULSE + 2, "R2", "write ready latency", n, B_TURN + B_PULSE + 2);
        chk(we_lo == B_PULSE, "R6", "write pulse cycles", we_lo, B_PULSE);
        chk(drv == B_PULSE + 1, "R8", "drive cycles", drv, B_PULSE + 1);
        chk(!mem_dq_oe && !sel_on, "R7", "release after hold", {mem_dq_oe, sel_on}, 2'b00);
        for (int k = 0; k < LN; k++)
            if (m[k]) shadow[a[5:0]][k*8 +: 8] = d[k*8 +: 8];
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [LN-1:0] m);
        int n;
        logic [DW-1:0] exp;
        issue(1'b0, a, '0, m);
        n = 1;
        chk(sel_on && !mem_rd_en_n && mem_wr_en_n && !req_ready, "R3", "read strobes",
            {mem_sel_n, mem_sel, mem_rd_en_n, mem_wr_en_n, req_ready}, 5'b01010);
        chk(mem_lane_n == ~m && mem_addr == a, "R3", "read lanes/addr", {14'd0, mem_lane_n, mem_addr}, {14'd0, ~m, a});
        while (!rsp_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        exp = shadow[a[5:0]] & lane_bits(m);
        chk(n == B_RD + 1, "R4", "read response latency", n, B_RD + 1);
        chk(rsp_rdata == exp, "R4", "read data", rsp_rdata, exp);
        chk(req_ready, "R2", "ready after read", req_ready, 1);
        @(negedge clk);
        chk(!rsp_valid, "R4", "response pulse width", rsp_valid, 0);
    endtask

    function automatic logic [AW-1:0] addr_of(input int i);
        return AW'(i * 18'h01041);
    endfunction

    initial begin
        for (int k = 0; k < 64; k++) begin
            model_mem[k] = '0;
            shadow[k]    = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        chk(req_ready && mem_sel_n && !mem_sel && mem_rd_en_n && mem_wr_en_n &&
            mem_lane_n == 2'b11 && !mem_dq_oe && !rsp_valid, "R1", "reset outputs",
            {req_ready, mem_sel_n, mem_sel, mem_rd_en_n, mem_wr_en_n, mem_lane_n, mem_dq_oe, rsp_valid},
            9'b110111100);

        for (int i = 0; i < 16; i++) do_write(addr_of(i), 16'((i + 1) * 16'h1357), 2'b11);
        for (int i = 0; i < 16; i++) do_read(addr_of(i), 2'b11);
        // R9: every mask value, including none
        for (int i = 0; i < 16; i++)
            do_write(addr_of(i), ~16'((i + 1) * 16'h1357) ^ 16'h00F0, LN'(i % 4));
        for (int i = 0; i < 16; i++)
            for (int m = 0; m < 4; m++) do_read(addr_of(i), LN'(m));
        // write directly after a read: turnaround
        for (int i = 0; i < 8; i++) begin
            do_read(addr_of(i), 2'b11);
            do_write(addr_of(i + 8), 16'(i * 16'h2B1D + 7), 2'b11);
            do_read(addr_of(i + 8), 2'b10);
        end
        chk(viol == 0, "R8", "memory timing violations", viol, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CP * 150000);
        n_fail++;
        $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule